// File: doc/BRIEF.md
# Flash Controller Control and Status Register Pair

This block holds the two byte-wide registers through which software drives an on-chip flash controller. A processor reaches them over a plain register port: an address, a write strobe, write data, and combinational read data. The registers hold the rewrite-mode enable, two block-protection enables, a mode-1 select, a stop bit and a wait-state bit for flash blocks A and B. They also show the engine's ready state and two sticky error flags.

The mode and protection bits are guarded. Such a bit becomes 1 only when a write of 1 comes right after a write of 0 to the same bit. Nothing else may come between the two writes: no other register write, and no cycle with interrupt or DMA activity. The block-level enables and mode-1 select also need rewrite mode to be on already. Clearing rewrite mode clears them on the same edge. The stop request reaches the flash only while rewrite mode is on. The wait output adds one wait state to every access to blocks A and B when the wait bit is set.

Top module: `flashctl_regs`

## Requirements
- R1: After reset, register 0 (address 0x1B7) reads 0x01 while the ready input is 1, register 1 (address 0x1B5) reads 0x00, and `flash_stop` is 0.
- R2: Register 0 bit 0 always shows the `eng_ready` input (1 means ready, 0 means busy), and bus writes to it have no effect.
- R3: Register 0 bit 1 (rewrite enable) becomes 1 only on a write with bit 1 = 1 that immediately follows a write to register 0 with bit 1 = 0. A lone write of 1 leaves the bit at 0. A write of 0 clears it.
- R4: The arming left by a write of 0 is cancelled by any write to the other register, and by `irq_dma_busy` being high in the 0-write cycle, in any cycle between the two writes, or in the 1-write cycle. After a cancelled arming, the next write of 1 is rejected.
- R5: Register 0 bit 2 (block 0-1 enable), register 1 bit 1 (mode-1 select) and register 1 bit 6 (block 0-5 enable) follow the same 0-then-1 rule. They also become 1 only while rewrite enable is already 1.
- R6: A write that clears rewrite enable also clears register 0 bit 2 and register 1 bits 1 and 6 on the same clock edge.
- R7: Register 0 bit 3 (stop) is an ordinary read/write bit. `flash_stop` is high only while both stop and rewrite enable are 1.
- R8: Register 0 bit 6 (program error) and bit 7 (erase error) are set by one-cycle pulses and hold until an `eng_clr_status` pulse. A set pulse in the same cycle as a clear leaves the flag at 1. Bus writes do not change either flag.
- R9: Register 1 bit 7 is an ordinary read/write bit. `wait_req` = `gen_wait` OR (`acc_blk_ab` AND bit 7).
- R10: Register 0 bits 4-5 and register 1 bits 0, 2, 3, 4 and 5 always read 0. A read from any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Register address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| eng_ready | input | 1 | Flash engine ready (1) / busy (0) |
| eng_prog_err | input | 1 | One-cycle program-error pulse |
| eng_erase_err | input | 1 | One-cycle erase-error pulse |
| eng_clr_status | input | 1 | One-cycle clear-status pulse |
| irq_dma_busy | input | 1 | Interrupt or DMA activity in this cycle |
| acc_blk_ab | input | 1 | Current access targets flash block A or B |
| gen_wait | input | 1 | General wait-state setting |
| wait_req | output | 1 | Insert one wait state on the current access |
| flash_stop | output | 1 | Stop and reset request to the flash |

## Verification
The assertions assume that the error and clear-status inputs are single-cycle pulses. They also assume that every input is already settled at the clock edge, so that a 1-write and any interrupt activity in the same cycle are seen together. The bench drives every input on the falling edge and holds each pulse for exactly one cycle. It makes at most one bus write per cycle and leaves the write strobe low while it reads back. That way no read-back cancels a pending arming.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_GRD  = 4;

    // Guarded bit indices
    localparam int GI_REN   = 0;
    localparam int GI_BLK01 = 1;
    localparam int GI_MODE1 = 2;
    localparam int GI_BLK05 = 3;

    typedef struct packed {
        logic       err_erase;
        logic       err_prog;
        logic [1:0] rsv;
        logic       stop;
        logic       blk01_en;
        logic       rw_en;
        logic       ready;
    } cr0_t;

    typedef struct packed {
        logic       ab_wait;
        logic       blk05_en;
        logic [3:0] rsv_hi;
        logic       mode1;
        logic       rsv_lo;
    } cr1_t;

    // Which register holds guarded bit i (0 or 1)
    function automatic int grd_reg(input int i);
        return (i == GI_MODE1 || i == GI_BLK05) ? 1 : 0;
    endfunction

    // Bit position of guarded bit i inside its register
    function automatic int grd_pos(input int i);
        case (i)
            GI_REN:   return 1;
            GI_BLK01: return 2;
            GI_MODE1: return 1;
            default:  return 6;
        endcase
    endfunction

endpackage

// File: rtl/flashctl_guard.sv
module flashctl_guard (
    input  logic clk,
    input  logic rst,
    input  logic sel_wr,
    input  logic oth_wr,
    input  logic wbit,
    input  logic busy,
    input  logic allow,
    input  logic force_clr,
    output logic q
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (force_clr)
                q <= 1'b0;
            else if (sel_wr && !wbit)
                q <= 1'b0;
            else if (sel_wr && wbit && armed && allow && !busy)
                q <= 1'b1;

            if (busy || oth_wr)
                armed <= 1'b0;
            else if (sel_wr)
                armed <= !wbit;
        end
    end

    AST_SET_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(q) |-> ($past(armed) && !$past(busy) && $past(sel_wr))); // R3

    AST_SET_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (rst)
        $rose(q) |-> $past(allow)); // R5

endmodule

// File: rtl/flashctl_status.sv
module flashctl_status (
    input  logic clk,
    input  logic rst,
    input  logic prog_pulse,
    input  logic erase_pulse,
    input  logic clr,
    output logic err_prog,
    output logic err_erase
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_prog  <= 1'b0;
            err_erase <= 1'b0;
        end else begin
            err_prog  <= prog_pulse  | (err_prog  & ~clr);
            err_erase <= erase_pulse | (err_erase & ~clr);
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_prog && !clr) |=> err_prog); // R8

    AST_CLR_STATUS: assert property (@(posedge clk) disable iff (rst)
        (clr && !erase_pulse) |=> !err_erase); // R8

endmodule

// File: rtl/flashctl_wait.sv
module flashctl_wait (
    input  logic acc_ab,
    input  logic ab_wait,
    input  logic gen_wait,
    output logic wait_req
);
    always_comb begin
        if (acc_ab)
            wait_req = ab_wait | gen_wait;
        else
            wait_req = gen_wait;
    end
endmodule

// File: rtl/flashctl_regs.sv
module flashctl_regs
    import flashctl_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int CR0_ADDR = 'h1B7,
    parameter int CR1_ADDR = 'h1B5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_ready,
    input  logic              eng_prog_err,
    input  logic              eng_erase_err,
    input  logic              eng_clr_status,
    input  logic              irq_dma_busy,
    input  logic              acc_blk_ab,
    input  logic              gen_wait,
    output logic              wait_req,
    output logic              flash_stop
);
    localparam logic [ADDR_W-1:0] A0 = ADDR_W'(CR0_ADDR);
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(CR1_ADDR);

    logic [1:0]         hit;
    logic [1:0]         wr;
    logic [NUM_GRD-1:0] g_q;
    logic               ren_clr;
    logic               stop_q;
    logic               ab_wait_q;
    logic               err_prog;
    logic               err_erase;
    cr0_t               r0;
    cr1_t               r1;
    logic               unused_wbits;

    assign hit[0]       = (bus_addr == A0);
    assign hit[1]       = (bus_addr == A1);
    assign wr           = {2{bus_we}} & hit;
    assign ren_clr      = wr[0] & ~bus_wdata[grd_pos(GI_REN)];
    assign unused_wbits = ^{bus_wdata[5:4], bus_wdata[0]};

    generate
        for (genvar i = 0; i < NUM_GRD; i++) begin : g_grd
            localparam int RI = grd_reg(i);
            localparam int BP = grd_pos(i);
            logic allow_i;
            logic force_i;
            if (i == GI_REN) begin : g_master
                assign allow_i = 1'b1;
                assign force_i = 1'b0;
            end else begin : g_dep
                assign allow_i = g_q[GI_REN];
                assign force_i = ren_clr;
            end
            flashctl_guard u_guard (
                .clk       (clk),
                .rst       (rst),
                .sel_wr    (wr[RI]),
                .oth_wr    (bus_we & ~hit[RI]),
                .wbit      (bus_wdata[BP]),
                .busy      (irq_dma_busy),
                .allow     (allow_i),
                .force_clr (force_i),
                .q         (g_q[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q    <= 1'b0;
            ab_wait_q <= 1'b0;
        end else begin
            if (wr[0]) stop_q    <= bus_wdata[3];
            if (wr[1]) ab_wait_q <= bus_wdata[7];
        end
    end

    flashctl_status u_status (
        .clk         (clk),
        .rst         (rst),
        .prog_pulse  (eng_prog_err),
        .erase_pulse (eng_erase_err),
        .clr         (eng_clr_status),
        .err_prog    (err_prog),
        .err_erase   (err_erase)
    );

    flashctl_wait u_wait (
        .acc_ab   (acc_blk_ab),
        .ab_wait  (ab_wait_q),
        .gen_wait (gen_wait),
        .wait_req (wait_req)
    );

    assign flash_stop = stop_q & g_q[GI_REN];

    always_comb begin
        r0           = '0;
        r0.ready     = eng_ready;
        r0.rw_en     = g_q[GI_REN];
        r0.blk01_en  = g_q[GI_BLK01];
        r0.stop      = stop_q;
        r0.err_prog  = err_prog;
        r0.err_erase = err_erase;
        r1           = '0;
        r1.mode1     = g_q[GI_MODE1];
        r1.blk05_en  = g_q[GI_BLK05];
        r1.ab_wait   = ab_wait_q;
        if (hit[0])      bus_rdata = r0;
        else if (hit[1]) bus_rdata = r1;
        else             bus_rdata = '0;
    end

    AST_CASCADE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !g_q[GI_REN] |-> (g_q[GI_BLK01] == 1'b0 && g_q[GI_MODE1] == 1'b0 && g_q[GI_BLK05] == 1'b0)); // R6

    AST_AB_WAIT: assert property (@(posedge clk) disable iff (rst)
        (acc_blk_ab && ab_wait_q) |-> wait_req); // R9

    AST_STOP_NEEDS_REN: assert property (@(posedge clk) disable iff (rst)
        $rose(flash_stop) |-> g_q[GI_REN]); // R7

endmodule

// File: tb/flashctl_regs_bench.sv
module flashctl_regs_bench;

    localparam logic [8:0] A0 = 9'h1B7;
    localparam logic [8:0] A1 = 9'h1B5;

    typedef struct packed {
        logic       we;
        logic       sel1;
        logic [7:0] data;
        logic       irq;
        logic [7:0] e0;
        logic [7:0] e1;
        logic       fs;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t TAB [NV] = '{
        '{1'b1,1'b0,8'h02,1'b0,8'h01,8'h00,1'b0}, // R3 lone write of 1 rejected
        '{1'b1,1'b0,8'h00,1'b0,8'h01,8'h00,1'b0}, // R3 arm
        '{1'b1,1'b0,8'h02,1'b0,8'h03,8'h00,1'b0}, // R3 accepted
        '{1'b1,1'b1,8'h42,1'b0,8'h03,8'h00,1'b0}, // R5 unarmed rejected
        '{1'b1,1'b1,8'h00,1'b0,8'h03,8'h00,1'b0}, // R5 arm
        '{1'b1,1'b1,8'h42,1'b0,8'h03,8'h42,1'b0}, // R5 accepted
        '{1'b1,1'b0,8'h06,1'b0,8'h03,8'h42,1'b0}, // R4 disarmed by other reg
        '{1'b1,1'b0,8'h02,1'b0,8'h03,8'h42,1'b0}, // R5 arm blk01
        '{1'b1,1'b0,8'h06,1'b0,8'h07,8'h42,1'b0}, // R5 blk01 set
        '{1'b1,1'b0,8'h0E,1'b0,8'h0F,8'h42,1'b1}, // R7 stop with ren
        '{1'b1,1'b1,8'hFF,1'b0,8'h0F,8'hC2,1'b1}, // R9 R10 wait bit, reserved
        '{1'b1,1'b0,8'hFE,1'b0,8'h0F,8'hC2,1'b1}, // R8 R10 error/reserved writes
        '{1'b1,1'b0,8'h0C,1'b0,8'h09,8'h80,1'b0}, // R6 cascade clear
        '{1'b1,1'b1,8'h00,1'b0,8'h09,8'h00,1'b0}, // R5 arm with ren 0
        '{1'b1,1'b1,8'h42,1'b0,8'h09,8'h00,1'b0}, // R5 rejected, ren 0
        '{1'b1,1'b0,8'h08,1'b0,8'h09,8'h00,1'b0}, // R4 arm
        '{1'b1,1'b0,8'h0A,1'b1,8'h09,8'h00,1'b0}, // R4 irq on 1-write
        '{1'b1,1'b0,8'h08,1'b1,8'h09,8'h00,1'b0}, // R4 irq on 0-write
        '{1'b1,1'b0,8'h0A,1'b0,8'h09,8'h00,1'b0}, // R4 rejected
        '{1'b1,1'b0,8'h08,1'b0,8'h09,8'h00,1'b0}, // R4 arm
        '{1'b1,1'b1,8'h00,1'b0,8'h09,8'h00,1'b0}, // R4 other reg write
        '{1'b1,1'b0,8'h0A,1'b0,8'h09,8'h00,1'b0}, // R4 rejected
        '{1'b1,1'b0,8'h08,1'b0,8'h09,8'h00,1'b0}, // R3 arm
        '{1'b1,1'b0,8'h0A,1'b0,8'h0B,8'h00,1'b1}, // R3 R7 accepted, stop live
        '{1'b1,1'b0,8'h00,1'b0,8'h01,8'h00,1'b0}, // R3 clear, arm
        '{1'b0,1'b0,8'h00,1'b1,8'h01,8'h00,1'b0}, // R4 irq between writes
        '{1'b1,1'b0,8'h02,1'b0,8'h01,8'h00,1'b0}  // R4 rejected
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       eng_ready = 1'b1;
    logic       eng_prog_err = 1'b0;
    logic       eng_erase_err = 1'b0;
    logic       eng_clr_status = 1'b0;
    logic       irq_dma_busy = 1'b0;
    logic       acc_blk_ab = 1'b0;
    logic       gen_wait = 1'b0;
    logic       wait_req;
    logic       flash_stop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flashctl_regs u_flashctl_regs (
        .clk            (clk),
        .rst            (rst),
        .bus_addr       (bus_addr),
        .bus_we         (bus_we),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .eng_ready      (eng_ready),
        .eng_prog_err   (eng_prog_err),
        .eng_erase_err  (eng_erase_err),
        .eng_clr_status (eng_clr_status),
        .irq_dma_busy   (irq_dma_busy),
        .acc_blk_ab     (acc_blk_ab),
        .gen_wait       (gen_wait),
        .wait_req       (wait_req),
        .flash_stop     (flash_stop)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [8:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d, input logic irq);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; irq_dma_busy = irq;
        @(negedge clk);
        bus_we = 1'b0; irq_dma_busy = 1'b0;
    endtask

    task automatic pulse(input logic p, input logic e, input logic c);
        @(negedge clk);
        eng_prog_err = p; eng_erase_err = e; eng_clr_status = c;
        @(negedge clk);
        eng_prog_err = 1'b0; eng_erase_err = 1'b0; eng_clr_status = 1'b0;
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        rd(A0, d); check(d, 8'h01, "R1 reg0 reset");
        rd(A1, d); check(d, 8'h00, "R1 reg1 reset");
        check({7'b0, flash_stop}, 8'h00, "R1 flash_stop reset");
        rd(9'h1B6, d); check(d, 8'h00, "R10 unmapped address");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_addr = TAB[i].sel1 ? A1 : A0;
            bus_wdata = TAB[i].data;
            bus_we = TAB[i].we;
            irq_dma_busy = TAB[i].irq;
            @(negedge clk);
            bus_we = 1'b0; irq_dma_busy = 1'b0;
            rd(A0, d); check(d, TAB[i].e0, $sformatf("table row %0d reg0", i));
            rd(A1, d); check(d, TAB[i].e1, $sformatf("table row %0d reg1", i));
            check({7'b0, flash_stop}, {7'b0, TAB[i].fs}, $sformatf("table row %0d flash_stop R7", i));
        end

        // R2: ready flag follows input
        eng_ready = 1'b0;
        rd(A0, d); check(d, 8'h00, "R2 busy shown");
        eng_ready = 1'b1;
        wr(A0, 8'h01, 1'b0);
        rd(A0, d); check(d, 8'h01, "R2 write to ready ignored");

        // R8: error flags
        pulse(1'b1, 1'b0, 1'b0);
        rd(A0, d); check(d, 8'h41, "R8 program error set");
        pulse(1'b0, 1'b1, 1'b0);
        rd(A0, d); check(d, 8'hC1, "R8 erase error set");
        wr(A0, 8'h00, 1'b0);
        rd(A0, d); check(d, 8'hC1, "R8 bus write ignored");
        pulse(1'b0, 1'b0, 1'b1);
        rd(A0, d); check(d, 8'h01, "R8 clear status");
        pulse(1'b1, 1'b0, 1'b1);
        rd(A0, d); check(d, 8'h41, "R8 set wins over clear");
        pulse(1'b0, 1'b0, 1'b1);

        // R9: wait request
        wr(A1, 8'h00, 1'b0);
        acc_blk_ab = 1'b1; gen_wait = 1'b0; #1;
        check({7'b0, wait_req}, 8'h00, "R9 AB no wait bit");
        wr(A1, 8'h80, 1'b0);
        rd(A1, d); check(d, 8'h80, "R9 wait bit reads back");
        acc_blk_ab = 1'b1; gen_wait = 1'b0; #1;
        check({7'b0, wait_req}, 8'h01, "R9 AB forced wait");
        acc_blk_ab = 1'b0; gen_wait = 1'b0; #1;
        check({7'b0, wait_req}, 8'h00, "R9 other block no wait");
        acc_blk_ab = 1'b0; gen_wait = 1'b1; #1;
        check({7'b0, wait_req}, 8'h01, "R9 general wait");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule